// File: doc/BRIEF.md
# Byte Rotate and Shift Unit

This unit performs the single-byte rotate and shift operations of an 8-bit processor and produces the flag byte for each one. The caller supplies the operand byte, a second byte that stands in for a memory location, the current flag byte and a 4-bit operation code. The unit returns the new operand byte, the new memory byte and the new flag byte.

The operations fall into three groups. The first group is the full rotates and shifts, which update every flag. The second group is the accumulator-only rotates, which update only the carry and clear two other flags. The third group is a pair of nibble exchanges between the operand and the memory byte.

A build parameter selects the output timing. With `REG_OUT` = 0 the outputs are purely combinational. With `REG_OUT` = 1 all three outputs are captured in a register, which adds one cycle of latency.

Top module: `byte_rotator`

## Requirements
- R1: Flag byte bit positions are S=7, Z=6, X5=5, H=4, X3=3, P=2, N=1, C=0. Op 0 rotates left circularly (bit 7 goes to bit 0), op 1 rotates right circularly (bit 0 goes to bit 7); in both, C takes the bit that left the byte.
- R2: Op 2 rotates left through carry (old C enters bit 0, bit 7 becomes C); op 3 rotates right through carry (old C enters bit 7, bit 0 becomes C).
- R3: Op 4 shifts left with a zero entering bit 0; op 6 shifts left with a one entering bit 0; both move bit 7 into C.
- R4: Op 5 shifts right keeping bit 7 unchanged; op 7 shifts right with zero entering bit 7; both move bit 0 into C.
- R5: For ops 0 to 7, S is result bit 7, Z is set when the result is zero, P is set when the result has an even number of ones, and H, N, X5 and X3 are zero.
- R6: Ops 8, 9, 10 and 11 produce the same result byte and C as ops 0, 1, 2 and 3 respectively, clear H and N, and pass S, Z, X5, X3 and P from the incoming flags unchanged.
- R7: Op 12 (nibble left): new operand = {operand[7:4], mem[7:4]}; new memory = {mem[3:0], operand[3:0]}.
- R8: Op 13 (nibble right): new operand = {operand[7:4], mem[3:0]}; new memory = {operand[3:0], mem[7:4]}.
- R9: For ops 12 and 13, S, Z and P (even parity) come from the new operand, H, N, X5 and X3 are zero, and C keeps its incoming value.
- R10: For every op other than 12 and 13, the memory output equals the memory input. Ops 14 and 15 pass the operand and the flags through unchanged.
- R11: With REG_OUT=1 the outputs show the result for the inputs present at the previous rising clock edge, and an active-low reset clears all outputs to zero. With REG_OUT=0 the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Byte to rotate or shift (accumulator for nibble ops) |
| mem_in | input | 8 | Memory byte used by the nibble ops |
| flags_in | input | 8 | Incoming flag byte |
| result | output | 8 | New operand byte |
| mem_out | output | 8 | New memory byte |
| flags_out | output | 8 | New flag byte |

## Verification
The bench instantiates the unit twice, once with REG_OUT=0 and once with REG_OUT=1, and drives both from the same stimulus. This reaches the same-cycle path and the one-cycle registered path, including the zeroed register state while reset is held. For every operation code, each of the 256 operand values is applied with the carry both clear and set. The other incoming flag bits are varied so that the pass-through of S, Z, P, X5 and X3 is observed. The memory byte is also varied so that both nibble halves are exercised.

// File: rtl/byte_rotator.sv
module byte_rotator #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] mem_in,
  input  logic [7:0]   flags_in,
  output logic [W-1:0] result,
  output logic [W-1:0] mem_out,
  output logic [7:0]   flags_out
);

  localparam int H = W / 2;
  localparam int FS = 7, FZ = 6, FX5 = 5, FH = 4, FX3 = 3, FP = 2, FN = 1, FC = 0;

  localparam logic [3:0] OP_ROL8 = 4'd0,  OP_ROR8 = 4'd1,  OP_ROL9 = 4'd2,  OP_ROR9 = 4'd3;
  localparam logic [3:0] OP_SHL0 = 4'd4,  OP_SHRA = 4'd5,  OP_SHL1 = 4'd6,  OP_SHRL = 4'd7;
  localparam logic [3:0] OP_AROL8 = 4'd8, OP_AROR8 = 4'd9, OP_AROL9 = 4'd10, OP_AROR9 = 4'd11;
  localparam logic [3:0] OP_NIBL = 4'd12, OP_NIBR = 4'd13;

  logic [W-1:0] r_n, m_n;
  logic         spill;
  logic [7:0]   f_n;
  logic         cin;

  assign cin = flags_in[FC];

  always_comb begin
    r_n   = operand;
    m_n   = mem_in;
    spill = cin;
    case (op_sel)
      OP_ROL8, OP_AROL8: begin r_n = {operand[W-2:0], operand[W-1]}; spill = operand[W-1]; end
      OP_ROR8, OP_AROR8: begin r_n = {operand[0], operand[W-1:1]};   spill = operand[0];   end
      OP_ROL9, OP_AROL9: begin r_n = {operand[W-2:0], cin};          spill = operand[W-1]; end
      OP_ROR9, OP_AROR9: begin r_n = {cin, operand[W-1:1]};          spill = operand[0];   end
      OP_SHL0: begin r_n = {operand[W-2:0], 1'b0};         spill = operand[W-1]; end
      OP_SHL1: begin r_n = {operand[W-2:0], 1'b1};         spill = operand[W-1]; end
      OP_SHRA: begin r_n = {operand[W-1], operand[W-1:1]}; spill = operand[0];   end
      OP_SHRL: begin r_n = {1'b0, operand[W-1:1]};         spill = operand[0];   end
      OP_NIBL: begin
        r_n = {operand[W-1:H], mem_in[W-1:H]};
        m_n = {mem_in[H-1:0], operand[H-1:0]};
      end
      OP_NIBR: begin
        r_n = {operand[W-1:H], mem_in[H-1:0]};
        m_n = {operand[H-1:0], mem_in[W-1:H]};
      end
      default: ;
    endcase
  end

  always_comb begin
    f_n = flags_in;
    if (op_sel <= OP_SHRL || op_sel == OP_NIBL || op_sel == OP_NIBR) begin
      f_n      = 8'h00;
      f_n[FS]  = r_n[W-1];
      f_n[FZ]  = (r_n == '0);
      f_n[FP]  = ~^r_n;
      f_n[FC]  = spill;
    end else if (op_sel <= OP_AROR9) begin
      f_n[FC] = spill;
      f_n[FH] = 1'b0;
      f_n[FN] = 1'b0;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          result    <= '0;
          mem_out   <= '0;
          flags_out <= '0;
        end else begin
          result    <= r_n;
          mem_out   <= m_n;
          flags_out <= f_n;
        end
      end
    end else begin : g_comb
      assign result    = r_n;
      assign mem_out   = m_n;
      assign flags_out = f_n;
    end
  endgenerate

  // Observation copy of the inputs aligned with the outputs, for the checks below
  logic [3:0]   o_op;
  logic [W-1:0] o_a, o_m;
  logic [7:0]   o_f;
  logic         o_ok;

  generate
    if (REG_OUT) begin : g_obs_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          o_op <= '0; o_a <= '0; o_m <= '0; o_f <= '0; o_ok <= 1'b0;
        end else begin
          o_op <= op_sel; o_a <= operand; o_m <= mem_in; o_f <= flags_in; o_ok <= 1'b1;
        end
      end
    end else begin : g_obs_comb
      assign o_op = op_sel;
      assign o_a  = operand;
      assign o_m  = mem_in;
      assign o_f  = flags_in;
      assign o_ok = 1'b1;
    end
  endgenerate

  assert_circ_reentry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op == OP_ROL8) |-> (result[0] == flags_out[FC] && flags_out[FC] == o_a[W-1]));
  assert_thru_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op == OP_ROL9) |-> (result[0] == o_f[FC] && flags_out[FC] == o_a[W-1]));
  assert_fill_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op == OP_SHL1) |-> (result[0] && flags_out[FC] == o_a[W-1]));
  assert_sign_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op == OP_SHRA) |-> (result[W-1] == o_a[W-1] && flags_out[FC] == o_a[0]));
  assert_full_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op <= OP_SHRL) |-> (flags_out[FH] == 1'b0 && flags_out[FN] == 1'b0 && flags_out[FX5] == 1'b0 && flags_out[FX3] == 1'b0));
  assert_partial_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op >= OP_AROL8 && o_op <= OP_AROR9) |->
      (flags_out[FS] == o_f[FS] && flags_out[FZ] == o_f[FZ] && flags_out[FP] == o_f[FP] &&
       flags_out[FX5] == o_f[FX5] && flags_out[FX3] == o_f[FX3] && !flags_out[FH] && !flags_out[FN]));
  assert_nib_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && (o_op == OP_NIBL || o_op == OP_NIBR)) |->
      (flags_out[FC] == o_f[FC] && result[W-1:H] == o_a[W-1:H]));
  assert_mem_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_op != OP_NIBL && o_op != OP_NIBR) |-> (mem_out == o_m));

endmodule

// File: tb/byte_rotator_tb.sv
module byte_rotator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] operand = '0, mem_in = '0, flags_in = '0;
  logic [7:0] res_c, mem_c, flg_c, res_r, mem_r, flg_r;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_rotator #(.W(8), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand), .mem_in(mem_in),
    .flags_in(flags_in), .result(res_r), .mem_out(mem_r), .flags_out(flg_r));

  byte_rotator #(.W(8), .REG_OUT(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand), .mem_in(mem_in),
    .flags_in(flags_in), .result(res_c), .mem_out(mem_c), .flags_out(flg_c));

  function automatic string tag_of(input int op);
    if (op <= 1) return "R1";
    if (op <= 3) return "R2";
    if (op == 4 || op == 6) return "R3";
    if (op <= 7) return "R4";
    if (op <= 11) return "R6";
    if (op == 12) return "R7";
    if (op == 13) return "R8";
    return "R10";
  endfunction

  function automatic bit even_ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return (n % 2) == 0;
  endfunction

  // Independent model: returns {flags, mem, result}
  function automatic logic [23:0] model(input int op, input logic [7:0] a, input logic [7:0] m, input logic [7:0] f);
    logic [8:0] w;
    logic [7:0] r, mo, fo;
    logic c;
    int base;
    r = a; mo = m; fo = f; c = f[0];
    base = (op >= 8 && op <= 11) ? op - 8 : op;
    case (base)
      0: begin w = {a, a[7]};            r = w[7:0]; c = a[7]; end
      1: begin w = {a[0], a};            r = w[8:1]; c = a[0]; end
      2: begin w = {a, f[0]};            r = w[7:0]; c = a[7]; end
      3: begin w = {f[0], a};            r = w[8:1]; c = a[0]; end
      4: begin r = a * 2;                 c = a[7]; end
      5: begin r = (a / 2) | (a & 8'h80); c = a[0]; end
      6: begin r = (a * 2) + 1;           c = a[7]; end
      7: begin r = a / 2;                 c = a[0]; end
      12: begin r = (a & 8'hF0) | (m >> 4);   mo = ((m & 8'h0F) << 4) | (a & 8'h0F); end
      13: begin r = (a & 8'hF0) | (m & 8'h0F); mo = ((a & 8'h0F) << 4) | (m >> 4);   end
      default: ;
    endcase
    if (op <= 7 || op == 12 || op == 13) begin
      fo = {r[7], r == 8'h00, 1'b0, 1'b0, 1'b0, even_ones(r), 1'b0, c};
    end else if (op <= 11) begin
      fo = f; fo[0] = c; fo[4] = 1'b0; fo[1] = 1'b0;
    end
    return {fo, mo, r};
  endfunction

  task automatic cmp(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%02h m=%02h f=%02h actual=%02h expected=%02h",
               tag, what, op_sel, operand, mem_in, flags_in, got, exp);
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    operand = 8'hA5; mem_in = 8'h3C; flags_in = 8'hFF; op_sel = 4'd12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R11", "reset result", res_r, 8'h00);
    cmp("R11", "reset mem", mem_r, 8'h00);
    cmp("R11", "reset flags", flg_r, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic apply(input int op, input logic [7:0] a, input logic [7:0] m, input logic [7:0] f);
    logic [23:0] e;
    @(negedge clk);
    op_sel = op[3:0]; operand = a; mem_in = m; flags_in = f;
    e = model(op, a, m, f);
    #1;
    cmp(tag_of(op), "comb result", res_c, e[7:0]);
    cmp(op >= 12 && op <= 13 ? tag_of(op) : "R10", "comb mem", mem_c, e[15:8]);
    cmp((op <= 7) ? "R5" : (op == 12 || op == 13) ? "R9" : tag_of(op), "comb flags", flg_c, e[23:16]);
    @(posedge clk); #1;
    cmp("R11", "reg result", res_r, e[7:0]);
    cmp("R11", "reg mem", mem_r, e[15:8]);
    cmp("R11", "reg flags", flg_r, e[23:16]);
  endtask

  task automatic test_sweep(input int op);
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 2; c++)
        apply(op, a[7:0], (a * 37 + 91) & 8'hFF, {((a * 13) & 8'hFE) | c});
  endtask

  task automatic test_latency;
    // R11: registered output holds the previous edge's value until the next edge
    @(negedge clk);
    op_sel = 4'd4; operand = 8'h81; mem_in = 8'h00; flags_in = 8'h00;
    @(posedge clk); #1;
    cmp("R11", "latency first", res_r, 8'h02);
    @(negedge clk);
    operand = 8'h40;
    #1;
    cmp("R11", "latency hold", res_r, 8'h02);
    cmp("R11", "comb same cycle", res_c, 8'h80);
    @(posedge clk); #1;
    cmp("R11", "latency next", res_r, 8'h80);
  endtask

  initial begin
    test_reset();
    test_latency();
    for (int op = 0; op < 16; op++) test_sweep(op);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule